// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A watchdog peripheral whose timeout counter runs on a core clock while software programs it through an APB slave on a separate bus clock, each domain with its own active-low reset. The counter counts down from a programmed timeout. In two-phase mode, the first time the counter reaches zero raises a level interrupt and reloads the timeout. If the counter runs out again before software clears that interrupt, a system reset request is raised. The reset request can be disabled, and a single-phase mode sends the first expiry straight to the reset request.

Software keeps the system alive by writing the clear register. The write drops the interrupt and restarts the count from the timeout value. Writes to the timeout, control and clear registers reach the core domain as toggle events. The running count is carried back to the bus side by a four-phase request/acknowledge loop. The loop holds the sampled value still while the bus side takes it, so a read of the count lags the counter by a few cycles. The APB slave never stalls: `pready` is always high, and there is no data stream that needs back-pressure.

Register offsets (bus bytes): 0x00 timeout value (read/write), 0x04 current count (read only), 0x08 control (bit 0 run, bit 1 reset allowed, bit 2 single-phase), 0x0C interrupt clear (write any value, reads 0), 0x10 status (bit 0 raw interrupt, bit 1 interrupt masked by the run bit).

Top module: `two_stage_wdog`

## Requirements
- R1: After both resets the interrupt and reset request are low, and the timeout, control and status registers read 0.
- R2: In two-phase mode with reset allowed, the first expiry raises the interrupt and reloads the count. The reset request rises exactly timeout+1 core cycles after the interrupt rises.
- R3: With control bit 1 (reset allowed) at 0, a second expiry gives no reset request. The interrupt stays high and the counter keeps reloading.
- R4: With control bit 2 (single-phase) at 1, the interrupt never rises. An expiry raises the reset request directly when bit 1 is 1, and only reloads the count when bit 1 is 0.
- R5: A write to offset 0x0C lowers the interrupt and reloads the count from the timeout value, so writes made more often than the timeout prevent both the interrupt and the reset request.
- R6: A timeout of zero expires on the next enabled core clock, so in two-phase mode the reset request follows the interrupt by one core cycle.
- R7: With control bit 0 (run) at 0, the counter holds its value, and repeated reads of offset 0x04 return the same value.
- R8: The reset request, once raised, stays high until the core reset is applied, even if the clear register is written.
- R9: Offsets 0x00 and 0x08 read back the values written. Offset 0x10 reads 3 while the interrupt is pending and the run bit is 1.
- R10: While running, successive reads of offset 0x04 fall and never exceed the timeout value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | CNT_W | APB write data |
| prdata | output | CNT_W | APB read data |
| pready | output | 1 | APB ready, always high |
| core_clk | input | 1 | Counter clock |
| core_rst_n | input | 1 | Core-domain reset, active low |
| wdt_irq | output | 1 | Warning interrupt, level high |
| wdt_rst_req | output | 1 | System reset request, sticky until core reset |

## Verification
The core-domain assertions assume that each configuration value captured on a toggle event was stable across the synchronizer delay. In other words, software leaves several core cycles between writes to the same register. The bench follows this rule by idling eight core cycles after every bus write. The assertions also assume that both resets are applied together before a new configuration. The bench resets both domains at the start of each table entry, so no toggle left over from an earlier entry replays into the core side.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned OFS_LOAD  = 8'h00;
  localparam int unsigned OFS_COUNT = 8'h04;
  localparam int unsigned OFS_CTRL  = 8'h08;
  localparam int unsigned OFS_CLEAR = 8'h0C;
  localparam int unsigned OFS_STAT  = 8'h10;

  localparam int unsigned EV_LOAD = 0;
  localparam int unsigned EV_CTRL = 1;
  localparam int unsigned EV_CLR  = 2;
  localparam int unsigned EV_NUM  = 3;

  typedef struct packed {
    logic single;
    logic rst_en;
    logic run;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_tsync.sv
module wdt_tsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic dst_clk,
  input  logic dst_rst_n,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) chain_q <= '0;
    else            chain_q <= {chain_q[STAGES-1:0], tgl_i};
  end

  assign pulse_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  output logic [CNT_W-1:0]  load_o,
  output wdt_ctrl_t         ctrl_o,
  output logic [EV_NUM-1:0] evt_tgl_o,
  output logic              req_o,
  input  logic              ack_i,
  input  logic [CNT_W-1:0]  snap_i,
  input  logic              irq_i
);
  localparam int unsigned CW = $bits(wdt_ctrl_t);

  logic             wr;
  logic [1:0]       ack_s, irq_s;
  logic [CNT_W-1:0] shadow_q;

  assign wr = psel && penable && pwrite;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      load_o    <= '0;
      ctrl_o    <= '0;
      evt_tgl_o <= '0;
    end else if (wr) begin
      if (paddr == ADDR_W'(OFS_LOAD)) begin
        load_o             <= pwdata;
        evt_tgl_o[EV_LOAD] <= ~evt_tgl_o[EV_LOAD];
      end
      if (paddr == ADDR_W'(OFS_CTRL)) begin
        ctrl_o             <= wdt_ctrl_t'(pwdata[CW-1:0]);
        evt_tgl_o[EV_CTRL] <= ~evt_tgl_o[EV_CTRL];
      end
      if (paddr == ADDR_W'(OFS_CLEAR))
        evt_tgl_o[EV_CLR]  <= ~evt_tgl_o[EV_CLR];
    end
  end

  // four-phase count fetch: snapshot is stable whenever ack_s[1] == req_o == 1
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ack_s    <= '0;
      irq_s    <= '0;
      req_o    <= 1'b0;
      shadow_q <= '0;
    end else begin
      ack_s <= {ack_s[0], ack_i};
      irq_s <= {irq_s[0], irq_i};
      if (ack_s[1] == req_o) begin
        if (req_o) shadow_q <= snap_i;
        req_o <= ~req_o;
      end
    end
  end

  always_comb begin
    prdata = '0;
    unique case (paddr)
      ADDR_W'(OFS_LOAD):  prdata = load_o;
      ADDR_W'(OFS_COUNT): prdata = shadow_q;
      ADDR_W'(OFS_CTRL):  prdata = CNT_W'(ctrl_o);
      ADDR_W'(OFS_STAT):  prdata = CNT_W'({irq_s[1] & ctrl_o.run, irq_s[1]});
      default:            prdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              core_clk,
  input  logic              core_rst_n,
  input  logic [CNT_W-1:0]  load_i,
  input  wdt_ctrl_t         ctrl_i,
  input  logic [EV_NUM-1:0] evt_tgl_i,
  input  logic              req_i,
  output logic              ack_o,
  output logic [CNT_W-1:0]  snap_o,
  output logic              irq_o,
  output logic              rst_o
);
  logic [EV_NUM-1:0] ev;
  logic [CNT_W-1:0]  cnt_q, load_q;
  wdt_ctrl_t         ctrl_q;
  logic [1:0]        req_s;

  for (genvar g = 0; g < EV_NUM; g++) begin : g_evsync
    wdt_tsync #(.STAGES(STAGES)) i_sync (
      .dst_clk  (core_clk),
      .dst_rst_n(core_rst_n),
      .tgl_i    (evt_tgl_i[g]),
      .pulse_o  (ev[g])
    );
  end

  always_ff @(posedge core_clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      ctrl_q <= '0;
      irq_o  <= 1'b0;
      rst_o  <= 1'b0;
    end else begin
      if (ev[EV_LOAD]) load_q <= load_i;
      if (ev[EV_CTRL]) ctrl_q <= ctrl_i;
      if (!rst_o) begin
        if (ev[EV_CLR]) begin
          irq_o <= 1'b0;
          cnt_q <= ev[EV_LOAD] ? load_i : load_q;
        end else if (ev[EV_LOAD]) begin
          cnt_q <= load_i;
        end else if (ctrl_q.run) begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!ctrl_q.single && !irq_o) begin
            irq_o <= 1'b1;
            cnt_q <= load_q;
          end else if (ctrl_q.rst_en) begin
            rst_o <= 1'b1;
          end else begin
            cnt_q <= load_q;
          end
        end
      end
    end
  end

  always_ff @(posedge core_clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      req_s  <= '0;
      ack_o  <= 1'b0;
      snap_o <= '0;
    end else begin
      req_s <= {req_s[0], req_i};
      ack_o <= req_s[1];
      if (req_s[1] && !ack_o) snap_o <= cnt_q;
    end
  end

  AST_RST_STICKY: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    rst_o |=> rst_o); // R8
  AST_IRQ_HELD: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    irq_o && !ev[EV_CLR] |=> irq_o); // R2
  AST_NO_RST_WHEN_OFF: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    !ctrl_q.rst_en && !rst_o |=> !rst_o); // R3
  AST_SINGLE_NO_IRQ: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    ctrl_q.single && !irq_o |=> !irq_o); // R4
  AST_RST_NEEDS_IRQ: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    !ctrl_q.single && !irq_o && !rst_o |=> !rst_o); // R2
  AST_CLEAR_DROPS: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    ev[EV_CLR] && !rst_o |=> !irq_o); // R5
  AST_FROZEN: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    !ctrl_q.run && !ev[EV_CLR] && !ev[EV_LOAD] |=> $stable(cnt_q)); // R7
  AST_BELOW_LOAD: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    ctrl_q.run && !ev[EV_LOAD] && !ev[EV_CTRL] && cnt_q <= load_q |=> cnt_q <= load_q); // R10
endmodule

// File: rtl/two_stage_wdog.sv
module two_stage_wdog
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  output logic              pready,
  input  logic              core_clk,
  input  logic              core_rst_n,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  logic [CNT_W-1:0]  load_w, snap_w;
  wdt_ctrl_t         ctrl_w;
  logic [EV_NUM-1:0] tgl_w;
  logic              req_w, ack_w;

  assign pready = 1'b1;

  wdt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_regs (
    .pclk     (pclk),
    .presetn  (presetn),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .load_o   (load_w),
    .ctrl_o   (ctrl_w),
    .evt_tgl_o(tgl_w),
    .req_o    (req_w),
    .ack_i    (ack_w),
    .snap_i   (snap_w),
    .irq_i    (wdt_irq)
  );

  wdt_core #(.CNT_W(CNT_W), .STAGES(STAGES)) i_core (
    .core_clk  (core_clk),
    .core_rst_n(core_rst_n),
    .load_i    (load_w),
    .ctrl_i    (ctrl_w),
    .evt_tgl_i (tgl_w),
    .req_i     (req_w),
    .ack_o     (ack_w),
    .snap_o    (snap_w),
    .irq_o     (wdt_irq),
    .rst_o     (wdt_rst_req)
  );
endmodule

// File: tb/test_two_stage_wdog.sv
module test_two_stage_wdog;
  localparam int CORE_PER = 10;
  localparam int APB_PER  = 14;
  localparam int NVEC     = 6;
  // [17:2] timeout, [1] single-phase, [0] reset allowed
  localparam logic [17:0] VEC [NVEC] = '{
    {16'd5,  1'b0, 1'b1},
    {16'd0,  1'b0, 1'b1},
    {16'd12, 1'b0, 1'b1},
    {16'd4,  1'b1, 1'b1},
    {16'd6,  1'b0, 1'b0},
    {16'd3,  1'b1, 1'b0}
  };

  logic        pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        core_clk = 0, core_rst_n = 0;
  logic        wdt_irq, wdt_rst_req;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(APB_PER/2)  pclk = ~pclk;
  always #(CORE_PER/2) core_clk = ~core_clk;

  two_stage_wdog i_two_stage_wdog (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .core_clk(core_clk), .core_rst_n(core_rst_n),
    .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_core(input int n);
    for (int i = 0; i < n; i++) @(negedge core_clk);
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
    wait_core(8);
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk);
    penable = 1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic do_reset();
    presetn = 0; core_rst_n = 0;
    wait_core(5);
    presetn = 1; core_rst_n = 1;
    wait_core(5);
  endtask

  task automatic wait_sig(input bit want_rst, input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge core_clk);
      seen = want_rst ? wdt_rst_req : wdt_irq;
    end
  endtask

  initial begin
    #(CORE_PER * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    bit seen;
    int n;

    // R1 reset state
    do_reset();
    chk("R1 irq", {31'b0, wdt_irq}, 0);
    chk("R1 rst", {31'b0, wdt_rst_req}, 0);
    apb_rd(8'h00, d); chk("R1 load", d, 0);
    apb_rd(8'h08, d); chk("R1 ctrl", d, 0);
    apb_rd(8'h10, d); chk("R1 stat", d, 0);
    chk("R1 pready", {31'b0, pready}, 1);

    // table of configurations
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] tmo;
      bit sgl, ren;
      tmo = VEC[v][17:2]; sgl = VEC[v][1]; ren = VEC[v][0];
      do_reset();
      apb_wr(8'h00, {16'b0, tmo});
      apb_wr(8'h08, {29'b0, sgl, ren, 1'b1});
      if (!sgl) begin
        wait_sig(0, 400, seen);
        chk("R2 irq rises", {31'b0, seen}, 1);
        if (ren) begin
          n = 0;
          do begin @(negedge core_clk); n++; end while (!wdt_rst_req && n < 1000);
          if (tmo == 0) chk("R6 zero timeout gap", n, 1);
          else          chk("R2 irq-to-reset gap", n, tmo + 1);
          apb_wr(8'h0C, 0);
          wait_core(40);
          chk("R8 reset sticky", {31'b0, wdt_rst_req}, 1);
        end else begin
          wait_core(4 * (tmo + 1) + 20);
          chk("R3 no reset", {31'b0, wdt_rst_req}, 0);
          chk("R3 irq held", {31'b0, wdt_irq}, 1);
        end
      end else begin
        if (ren) begin
          wait_sig(1, 400, seen);
          chk("R4 direct reset", {31'b0, seen}, 1);
          chk("R4 no irq", {31'b0, wdt_irq}, 0);
        end else begin
          wait_core(4 * (tmo + 1) + 20);
          chk("R4 reload only rst", {31'b0, wdt_rst_req}, 0);
          chk("R4 reload only irq", {31'b0, wdt_irq}, 0);
        end
      end
    end

    // R5 periodic kicks keep it quiet
    do_reset();
    apb_wr(8'h00, 40);
    apb_wr(8'h08, 32'h3);
    for (int k = 0; k < 6; k++) begin
      wait_core(15);
      apb_wr(8'h0C, 32'h5A);
    end
    chk("R5 kick irq", {31'b0, wdt_irq}, 0);
    chk("R5 kick rst", {31'b0, wdt_rst_req}, 0);
    // R9 readback and status with interrupt pending
    wait_sig(0, 200, seen);
    chk("R5 irq after kicks stop", {31'b0, seen}, 1);
    apb_rd(8'h10, d); chk("R9 status", d, 3);
    apb_rd(8'h00, d); chk("R9 load readback", d, 40);
    apb_rd(8'h08, d); chk("R9 ctrl readback", d, 3);
    apb_wr(8'h0C, 0);
    chk("R5 clear drops irq", {31'b0, wdt_irq}, 0);
    chk("R5 clear no reset", {31'b0, wdt_rst_req}, 0);

    // R10 count falls, R7 freeze
    do_reset();
    apb_wr(8'h00, 3000);
    apb_wr(8'h08, 32'h1);
    wait_core(30);
    apb_rd(8'h04, d);
    wait_core(60);
    apb_rd(8'h04, d2);
    chk("R10 count bounded", {31'b0, d <= 3000}, 1);
    chk("R10 count falls", {31'b0, d2 < d}, 1);
    apb_wr(8'h08, 32'h0);
    wait_core(30);
    apb_rd(8'h04, d);
    wait_core(80);
    apb_rd(8'h04, d2);
    chk("R7 frozen count", d2, d);
    chk("R7 frozen nonzero", {31'b0, d != 0}, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule